// File: doc/BRIEF.md
# Prefixed Instruction Decoder

This block turns a stream of 16-bit instruction words into control fields for an eight-register load/store processor. It accepts at most one word per cycle. One cycle later it presents these fields: operation class, ALU operation, the raw register fields, an immediate operand with its select bit, the memory access size, the branch condition and link bit, a 16-bit rotate flag and an illegal-instruction flag. Execution, memory, the register file and fetch belong to other blocks.

Two kinds of prefix word change how the following real instruction is decoded, and neither produces an output of its own.

- **Immediate prefix:** contributes 12 payload bits. The next consumer places these bits above its own small immediate field, so several prefixes in a row can build a full-width constant.
- **Alternate prefix:** supplies a 2-bit selector. The selector remaps the multiply group, sets the load/store size, and switches rotates to the 16-bit variant.

Both kinds of prefix state survive idle cycles. They are dropped after the next non-prefix word, whether that word is legal or reserved.

Top module: `pfx_decoder`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, every output is zero. A synchronous reset also discards any pending prefix state.
- R2: Each cycle with `in_valid` high carries a word.
  - For a non-prefix word, `dec_valid` is high in the next cycle.
  - For a prefix word, and for a cycle with `in_valid` low, every output is zero in the next cycle.
- R3: Short form (bits 15..12 in 0000–1011):
  - Opcodes 0000–0110 map to class ALU (1) with `alu_op` 0–6: ADD, ADC, RSB, RSBC, AND, OR, XOR.
  - Opcode 0111 is the multiply group.
  - The immediate field k is bits 11..6. Without a prefix it is sign-extended and `imm_sel` is 1.
  - `rx`, `ry` and `rz` always show bits 2..0, 5..3 and 8..6 of the word.
- R4: Opcode 1100 is class ALU with `alu_op` taken from bits 11..9 in the same order as R3. It has `imm_sel` 0 and `imm` 0, and its third register is in bits 8..6.
- R5: Opcode 1101 is load-immediate, class 5. k is bits 11..9..3 read as the 9-bit field bits 11..3, sign-extended when no prefix is pending.
- R6: Opcodes 1010 and 1011 are branches, class 4. `br_cond` shows bits 2..0, `br_link` is 1 only for 1011, and `alu_op` is ADD. In every other class `br_cond` and `br_link` are 0.
- R7: Opcode 1110 is an immediate prefix with a 12-bit payload.
  - Each prefix sets acc = (acc << 12) | payload.
  - The next consumer that has a k field receives imm = (acc << width(k)) | k, with k zero-extended and the result truncated to 32 bits.
- R8: An alternate prefix is the word 0xF760 + e, where e is 0–3. It sets the selector to e.
  - In the multiply group (R3, R4), e = 0, 1, 2, 3 give `alu_op` 7 MUL, 8 SMUL, 9 DIV, 10 SDIV.
  - The selector has no effect on other ALU operations.
- R9: Load (1000, class 2) and store (1001, class 3) take `mem_size` from the selector: 0 = 32-bit, 1 = 16-bit, 2 = 8-bit. Selector 3 on a load or store is illegal. `mem_size` is 0 for every other class.
- R10: Shift form 1111 00ss kkkkk rrr is class 6, with ss = 0–3 giving `alu_op` 11 ROR, 12 ROL, 13 LSL, 14 LSR. k is zero-extended. `rot16` is 1 only for ROR or ROL under a non-zero selector.
- R11: Move form 1111 0100 00 ry rx is class 7 with `alu_op` ADD and `imm_sel` 0.
- R12: All other 1111 words are reserved and illegal, including 0xF764–0xF767 and any move with bits 7..6 non-zero. An illegal word gives `dec_valid` and `illegal` high, with every other output 0, and it clears the prefix state.
- R13: The accumulator and the selector clear after any non-prefix word. They survive cycles with `in_valid` low, and each kind of prefix leaves the other kind's state untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | `instr` carries a word this cycle |
| instr | input | 16 | Instruction word |
| dec_valid | output | 1 | Decoded instruction present |
| illegal | output | 1 | Reserved encoding decoded |
| op_class | output | 3 | 0 none, 1 ALU, 2 load, 3 store, 4 branch, 5 load-immediate, 6 shift, 7 move |
| alu_op | output | 4 | ALU operation code (see R3, R8, R10) |
| rx | output | 3 | Word bits 2..0 |
| ry | output | 3 | Word bits 5..3 |
| rz | output | 3 | Word bits 8..6 |
| imm_sel | output | 1 | Second operand is the immediate |
| imm | output | 32 | Immediate operand |
| mem_size | output | 2 | 0 word, 1 half-word, 2 byte |
| br_cond | output | 3 | Branch condition code |
| br_link | output | 1 | Branch saves the return address |
| rot16 | output | 1 | Rotate acts on 16 bits |

## Verification
Prefix consumption and illegal detection can land on the same word. This happens when a reserved word, or a load or store under selector 3, arrives while an immediate prefix or an alternate prefix is pending. Directed sequences build exactly that situation, and a random mix of prefixes, idle cycles and arbitrary words builds it again many times. The behavioural model in the bench expects an all-zero illegal result in that cycle. It also expects the following consumer to see neither the accumulated payload nor the selector.

// File: rtl/pfx_dec_pkg.sv
package pfx_dec_pkg;
  localparam int ILEN  = 16;
  localparam int RW    = 3;
  localparam int KS_W  = 6;
  localparam int KL_W  = 9;
  localparam int KR_W  = 5;
  localparam int PFX_W = 12;
  localparam int EXT_W = 2;

  typedef enum logic [2:0] {
    CL_NONE, CL_ALU, CL_LOAD, CL_STORE, CL_BRANCH, CL_LDI, CL_SHIFT, CL_MOV
  } op_class_e;

  typedef enum logic [3:0] {
    OP_ADD, OP_ADC, OP_RSB, OP_RSBC, OP_AND, OP_OR, OP_XOR,
    OP_MUL, OP_SMUL, OP_DIV, OP_SDIV,
    OP_ROR, OP_ROL, OP_LSL, OP_LSR, OP_RSV
  } alu_op_e;

  typedef struct packed {
    logic              valid;
    logic              illegal;
    op_class_e         cls;
    alu_op_e           op;
    logic [RW-1:0]     rx;
    logic [RW-1:0]     ry;
    logic [RW-1:0]     rz;
    logic              imm_sel;
    logic [EXT_W-1:0]  msize;
    logic [RW-1:0]     cond;
    logic              link;
    logic              rot16;
  } dec_ctl_t;

  function automatic alu_op_e alu_sel(input logic [2:0] s, input logic [EXT_W-1:0] e);
    if (s == 3'd7) return alu_op_e'(4'd7 + {2'b00, e});
    return alu_op_e'({1'b0, s});
  endfunction
endpackage

// File: rtl/pfx_state.sv
module pfx_state
  import pfx_dec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             is_ipfx,
  input  logic             is_alt,
  input  logic [PFX_W-1:0] payload,
  input  logic [EXT_W-1:0] alt_ext,
  output logic [XLEN-1:0]  acc,
  output logic             pend,
  output logic [EXT_W-1:0] ext
);
  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      pend <= 1'b0;
      ext  <= '0;
    end else if (step) begin
      if (is_ipfx) begin
        acc  <= (acc << PFX_W) | XLEN'(payload);
        pend <= 1'b1;
      end else if (is_alt) begin
        ext <= alt_ext;
      end else begin
        acc  <= '0;
        pend <= 1'b0;
        ext  <= '0;
      end
    end
  end

  AST_STATE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (step && !is_ipfx && !is_alt) |=> (!pend && ext == '0 && acc == '0)); // R13
  AST_ALT_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
    (step && is_alt) |=> $stable(acc)); // R13
  AST_IPFX_KEEPS_EXT: assert property (@(posedge clk) disable iff (rst)
    (step && is_ipfx) |=> ($stable(ext) && pend)); // R7
endmodule

// File: rtl/pfx_field_decode.sv
module pfx_field_decode
  import pfx_dec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [ILEN-1:0]  instr,
  input  logic [EXT_W-1:0] ext,
  input  logic             pend,
  input  logic [XLEN-1:0]  acc,
  output dec_ctl_t         ctl,
  output logic [XLEN-1:0]  imm,
  output logic             is_ipfx,
  output logic             is_alt
);
  logic [3:0]      opc;
  logic [KS_W-1:0] k_s;
  logic [KL_W-1:0] k_l;
  logic [KR_W-1:0] k_r;
  logic            bad;

  assign opc = instr[15:12];
  assign k_s = instr[11:6];
  assign k_l = instr[11:3];
  assign k_r = instr[7:3];

  always_comb begin
    ctl     = '0;
    imm     = '0;
    is_ipfx = 1'b0;
    is_alt  = 1'b0;
    bad     = 1'b0;
    ctl.rx  = instr[2:0];
    ctl.ry  = instr[5:3];
    ctl.rz  = instr[8:6];
    case (opc)
      4'b1110: is_ipfx = 1'b1;
      4'b1100: begin
        ctl.cls = CL_ALU;
        ctl.op  = alu_sel(instr[11:9], ext);
      end
      4'b1101: begin
        ctl.cls     = CL_LDI;
        ctl.imm_sel = 1'b1;
        imm = pend ? ((acc << KL_W) | XLEN'(k_l))
                   : {{(XLEN-KL_W){k_l[KL_W-1]}}, k_l};
      end
      4'b1111: begin
        if (instr[11:10] == 2'b00) begin
          ctl.cls     = CL_SHIFT;
          ctl.op      = alu_op_e'(4'd11 + {2'b00, instr[9:8]});
          ctl.rot16   = (ext != '0) && !instr[9];
          ctl.imm_sel = 1'b1;
          imm = pend ? ((acc << KR_W) | XLEN'(k_r)) : XLEN'(k_r);
        end else if (instr[11:6] == 6'b010000) begin
          ctl.cls = CL_MOV;
        end else if (instr[11:2] == 10'b0111011000) begin
          is_alt = 1'b1;
        end else begin
          bad = 1'b1;
        end
      end
      default: begin
        ctl.imm_sel = 1'b1;
        imm = pend ? ((acc << KS_W) | XLEN'(k_s))
                   : {{(XLEN-KS_W){k_s[KS_W-1]}}, k_s};
        if (!opc[3]) begin
          ctl.cls = CL_ALU;
          ctl.op  = alu_sel(opc[2:0], ext);
        end else if (!opc[1]) begin
          ctl.cls   = opc[0] ? CL_STORE : CL_LOAD;
          ctl.msize = ext;
          bad       = (ext == 2'd3);
        end else begin
          ctl.cls  = CL_BRANCH;
          ctl.cond = instr[2:0];
          ctl.link = opc[0];
        end
      end
    endcase
    if (bad) begin
      ctl         = '0;
      imm         = '0;
      ctl.illegal = 1'b1;
    end
    ctl.valid = !(is_ipfx || is_alt);
  end

  always_comb begin
    assert ($onehot0({is_ipfx, is_alt, ctl.illegal})); // R12
  end
endmodule

// File: rtl/pfx_decoder.sv
module pfx_decoder
  import pfx_dec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [15:0]     instr,
  output logic            dec_valid,
  output logic            illegal,
  output logic [2:0]      op_class,
  output logic [3:0]      alu_op,
  output logic [2:0]      rx,
  output logic [2:0]      ry,
  output logic [2:0]      rz,
  output logic            imm_sel,
  output logic [XLEN-1:0] imm,
  output logic [1:0]      mem_size,
  output logic [2:0]      br_cond,
  output logic            br_link,
  output logic            rot16
);
  dec_ctl_t         dec_c, dec_q;
  logic [XLEN-1:0]  dec_imm, imm_q;
  logic             is_ipfx, is_alt, pend;
  logic [XLEN-1:0]  acc;
  logic [EXT_W-1:0] ext;

  pfx_state #(.XLEN(XLEN)) u_state (
    .clk(clk), .rst(rst), .step(in_valid),
    .is_ipfx(is_ipfx), .is_alt(is_alt),
    .payload(instr[PFX_W-1:0]), .alt_ext(instr[EXT_W-1:0]),
    .acc(acc), .pend(pend), .ext(ext)
  );

  pfx_field_decode #(.XLEN(XLEN)) u_fields (
    .instr(instr), .ext(ext), .pend(pend), .acc(acc),
    .ctl(dec_c), .imm(dec_imm), .is_ipfx(is_ipfx), .is_alt(is_alt)
  );

  always_ff @(posedge clk) begin
    if (rst || !in_valid || !dec_c.valid) begin
      dec_q <= '0;
      imm_q <= '0;
    end else begin
      dec_q <= dec_c;
      imm_q <= dec_imm;
    end
  end

  assign dec_valid = dec_q.valid;
  assign illegal   = dec_q.illegal;
  assign op_class  = dec_q.cls;
  assign alu_op    = dec_q.op;
  assign rx        = dec_q.rx;
  assign ry        = dec_q.ry;
  assign rz        = dec_q.rz;
  assign imm_sel   = dec_q.imm_sel;
  assign imm       = imm_q;
  assign mem_size  = dec_q.msize;
  assign br_cond   = dec_q.cond;
  assign br_link   = dec_q.link;
  assign rot16     = dec_q.rot16;

  AST_PFX_SILENT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (is_ipfx || is_alt)) |=> !dec_valid); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!dec_valid && !illegal)); // R2
  AST_WORD_VALID: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !is_ipfx && !is_alt) |=> dec_valid); // R2
  AST_ILL_ZERO: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (dec_valid && op_class == 3'd0 && imm == '0 && !imm_sel)); // R12
  AST_SIZE_MEM_ONLY: assert property (@(posedge clk) disable iff (rst)
    (op_class != 3'd2 && op_class != 3'd3) |-> mem_size == 2'd0); // R9
  AST_LINK_BRANCH: assert property (@(posedge clk) disable iff (rst)
    br_link |-> op_class == 3'd4); // R6
endmodule

// File: tb/pfx_decoder_bench.sv
module pfx_decoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] instr = '0;
  logic        dec_valid, illegal, imm_sel, br_link, rot16;
  logic [2:0]  op_class, rx, ry, rz, br_cond;
  logic [3:0]  alu_op;
  logic [31:0] imm;
  logic [1:0]  mem_size;

  pfx_decoder u_pfx_decoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .dec_valid(dec_valid), .illegal(illegal), .op_class(op_class),
    .alu_op(alu_op), .rx(rx), .ry(ry), .rz(rz), .imm_sel(imm_sel),
    .imm(imm), .mem_size(mem_size), .br_cond(br_cond),
    .br_link(br_link), .rot16(rot16)
  );

  always #10ns clk = ~clk;

  int checks = 0;
  int fails  = 0;

  logic [31:0] m_acc = '0;
  bit          m_pend = 0;
  int          m_ext = 0;
  logic [57:0] exp_vec = '0;
  string       exp_tag = "R1";

  function automatic logic [57:0] actual();
    return {dec_valid, illegal, op_class, alu_op, rx, ry, rz, imm_sel, imm,
            mem_size, br_cond, br_link, rot16};
  endfunction

  task automatic compare(input logic [57:0] e, input string tag);
    checks++;
    if (actual() !== e) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, actual(), e);
    end
  endtask

  task automatic model(input bit v, input logic [15:0] w, input string tag);
    int op, cls, aop, kw, msz, cnd;
    bit sgn, bad, lnk, r16, isel;
    logic [31:0] kv, e_imm;
    string t;
    exp_vec = '0;
    exp_tag = (tag != "") ? tag : "R2";
    if (!v) return;
    op = int'(w[15:12]);
    if (op == 14) begin
      m_acc = (m_acc << 12) | {20'd0, w[11:0]};
      m_pend = 1;
      if (tag == "") exp_tag = "R7";
      return;
    end
    if (op == 15 && w[11:0] >= 12'h760 && w[11:0] <= 12'h763) begin
      m_ext = int'(w[1:0]);
      if (tag == "") exp_tag = "R8";
      return;
    end
    cls = 0; aop = 0; kw = 0; msz = 0; cnd = 0;
    sgn = 0; bad = 0; lnk = 0; r16 = 0; isel = 0; kv = 0;
    t = "R3";
    if (op <= 7) begin
      cls = 1; kw = 6; sgn = 1;
      aop = (op == 7) ? 7 + m_ext : op;
      if (op == 7 && m_ext != 0) t = "R8";
    end else if (op == 8 || op == 9) begin
      cls = op - 6; kw = 6; sgn = 1; msz = m_ext; t = "R9";
      if (m_ext == 3) bad = 1;
    end else if (op == 10 || op == 11) begin
      cls = 4; kw = 6; sgn = 1; cnd = int'(w[2:0]); lnk = (op == 11); t = "R6";
    end else if (op == 12) begin
      cls = 1; t = "R4";
      aop = (w[11:9] == 3'd7) ? 7 + m_ext : int'(w[11:9]);
    end else if (op == 13) begin
      cls = 5; kw = 9; sgn = 1; t = "R5";
    end else if (w[11:10] == 2'b00) begin
      cls = 6; kw = 5; t = "R10";
      aop = 11 + int'(w[9:8]);
      r16 = (m_ext != 0) && (w[9:8] < 2);
    end else if (w[11:6] == 6'b010000) begin
      cls = 7; t = "R11";
    end else begin
      bad = 1;
    end
    e_imm = 0;
    if (kw > 0) begin
      isel = 1;
      kv = (w >> (kw == 5 ? 3 : (kw == 9 ? 3 : 6))) & ((32'd1 << kw) - 1);
      if (m_pend) begin
        e_imm = (m_acc << kw) | kv;
        t = "R7";
      end else if (sgn && kv[kw-1]) begin
        e_imm = kv - (32'd1 << kw);
      end else begin
        e_imm = kv;
      end
    end
    if (bad) begin
      exp_vec = {1'b1, 1'b1, 56'd0};
      t = "R12";
    end else begin
      exp_vec = {1'b1, 1'b0, 3'(cls), 4'(aop), w[2:0], w[5:3], w[8:6], isel,
                 e_imm, 2'(msz), 3'(cnd), lnk, r16};
    end
    exp_tag = (tag != "") ? tag : t;
    m_acc = 0; m_pend = 0; m_ext = 0;
  endtask

  task automatic step(input bit v, input logic [15:0] w, input string tag);
    @(negedge clk);
    compare(exp_vec, exp_tag);
    in_valid = v;
    instr = w;
    model(v, w, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    compare(exp_vec, exp_tag);
    rst = 1'b1;
    in_valid = 1'b0;
    m_acc = 0; m_pend = 0; m_ext = 0;
    @(negedge clk);
    compare('0, "R1");
    rst = 1'b0;
    exp_vec = '0;
    exp_tag = "R1";
  endtask

  initial begin
    #(20ns * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare('0, "R1");
    rst = 1'b0;
    exp_vec = '0;
    exp_tag = "R1";
    // short forms, three-register, load-immediate, branches
    step(1, 16'h0FD1, "R3");
    step(1, 16'h6055, "R3");
    step(1, 16'hC5D3, "R4");
    step(1, 16'hCFFF, "R4");
    step(1, 16'hDFFA, "R5");
    step(1, 16'hD7FA, "R5");
    step(1, 16'hA0D5, "R6");
    step(1, 16'hBFC2, "R6");
    step(0, 16'hFFFF, "R2");
    // immediate prefixes
    step(1, 16'hEABC, "R7");
    step(1, 16'h0041, "R7");
    step(1, 16'hE123, "R7");
    step(1, 16'hE456, "R7");
    step(1, 16'hE789, "R7");
    step(1, 16'hD00F, "R7");
    step(1, 16'h0041, "R13");
    // alternate prefix on multiply group, loads, rotates
    for (int e = 0; e < 4; e++) begin
      step(1, 16'hF760 | 16'(e), "R8");
      step(1, 16'h7000 | 16'(e), "R8");
      step(1, 16'hF760 | 16'(e), "R8");
      step(1, 16'hCE0A, "R8");
      step(1, 16'hF760 | 16'(e), e == 3 ? "R12" : "R9");
      step(1, 16'h8053, e == 3 ? "R12" : "R9");
      step(1, 16'hF760 | 16'(e), "R9");
      step(1, 16'h9053, e == 3 ? "R12" : "R9");
      for (int s = 0; s < 4; s++) begin
        step(1, 16'hF760 | 16'(e), "R10");
        step(1, 16'hF000 | 16'(s << 8) | 16'h00F9, "R10");
      end
    end
    // selector ignored by non-multiply ALU ops, and cleared after use
    step(1, 16'hF761, "R8");
    step(1, 16'h1000, "R8");
    step(1, 16'h7000, "R13");
    step(1, 16'hF762, "R13");
    step(0, 16'h0000, "R13");
    step(0, 16'h0000, "R13");
    step(1, 16'h7000, "R13");
    step(1, 16'hEFFF, "R13");
    step(1, 16'hF763, "R13");
    step(1, 16'hF3FF, "R13");
    // moves and reserved words
    step(1, 16'hF41A, "R11");
    step(1, 16'hF440, "R12");
    step(1, 16'hEFFF, "R12");
    step(1, 16'hF764, "R12");
    step(1, 16'h0FC0, "R12");
    step(1, 16'hF761, "R12");
    step(1, 16'hF900, "R12");
    step(1, 16'h7000, "R12");
    // reset discards pending prefixes
    step(1, 16'hE555, "R1");
    step(1, 16'hF762, "R1");
    do_reset();
    step(1, 16'h7FC0, "R1");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom % 8);
      if (r == 0)      step(1, 16'hE000 | 16'($urandom % 4096), "");
      else if (r == 1) step(1, 16'hF760 | 16'($urandom % 4), "");
      else if (r == 2) step(0, 16'($urandom), "");
      else             step(1, 16'($urandom), "");
    end
    step(0, 16'h0000, "");
    step(0, 16'h0000, "");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule